// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital half of a 12-bit successive-approximation analog-to-digital converter. It receives a start command, opens a gate on the conversion clock, and drives a trial code to an external capacitive DAC. It reads one comparator line to decide each bit. The comparator, DAC, reference and sampling network sit outside the block. The block only sequences them and keeps the resulting code.

A conversion runs to completion once it starts. While it runs, the status output stays high and the result port is held at zero. When the last bit is decided, the block gates the conversion clock off, drops the status output, and pulses an end-of-conversion flag. After that, a read strobe places the stored code on a registered output, with an enable beside it. The code stays stored until the next accepted start command, so it can be read any number of times.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A start command sampled high while idle is accepted. From the next cycle, `busy_o` and `conv_clk_en_o` are high and `trial_o` equals 0x800: the register is cleared and only the most significant bit is set.
- R2: Start commands that arrive while `busy_o` is high have no effect. The conversion keeps its length and timing, even when start is held high throughout.
- R3: While `busy_o` is high, `data_oe_o` is low and `data_o` is zero, whatever `read_i` does.
- R4: Bits are tried one per cycle, from bit 11 down to bit 0. In the k-th converting cycle (k = 1..12), `trial_o` has bit 12-k set and every lower bit clear.
- R5: `cmp_keep_i` high means the DAC output is at or below the input, and the trial bit is kept. When it is low, the trial bit is cleared. Bits already decided are never changed.
- R6: After the 12 decisions, the stored result equals the ideal code of the input. `busy_o` stays high for exactly 13 cycles: 12 bit cycles and one control cycle.
- R7: `conv_clk_en_o` is high only during the 12 bit cycles. `eoc_o` is a one-cycle pulse in the first cycle in which `busy_o` is low again.
- R8: When `read_i` is sampled high while the block is idle, and no start is being accepted at the same edge, the next cycle shows `data_oe_o` high and `data_o` equal to the result. Otherwise `data_o` is zero.
- R9: The result is held until the next accepted start, so repeated reads return the same code.
- R10: A synchronous active-high `rst` returns the block to idle from any state. After reset, `busy_o` is low, the clock gate is off and the result is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion start command |
| cmp_keep_i | input | 1 | Comparator: high when DAC output is at or below the input |
| read_i | input | 1 | Read strobe for the result buffers |
| conv_clk_en_o | output | 1 | Conversion clock gate enable |
| busy_o | output | 1 | Conversion in progress status |
| eoc_o | output | 1 | End-of-conversion pulse |
| trial_o | output | 12 | Trial code driven to the DAC |
| data_oe_o | output | 1 | Output buffer enable |
| data_o | output | 12 | Gated result, zero when not enabled |

## Verification
The hardest situations to reach involve collisions at the edges of a conversion. These are a start or read that arrives in the control cycle, in the cycle of the end pulse, or on the same edge as the other command. The bench reaches them by holding start and read high across whole conversions. It also issues a start right on the end pulse, which chains back-to-back conversions. A behavioural model counts cycles since the accepted start and predicts every output on every clock. Inputs of all zeros, all ones and alternating patterns make each bit take both decisions.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_END  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int W  = 12,
  parameter int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          load_o,
  output logic          step_o,
  output logic          last_o,
  output logic [IW-1:0] idx_o,
  output logic          idle_next_o,
  output logic          busy_o,
  output logic          clk_en_o,
  output logic          eoc_o
);
  localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

  seq_state_e    state_q, state_d;
  logic [IW-1:0] idx_q;

  assign load_o      = (state_q == ST_IDLE) && start_i;
  assign step_o      = (state_q == ST_CONV);
  assign last_o      = step_o && (idx_q == '0);
  assign idx_o       = idx_q;
  assign idle_next_o = (state_d == ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_CONV;
      ST_CONV: if (idx_q == '0) state_d = ST_END;
      ST_END:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      busy_o   <= 1'b0;
      clk_en_o <= 1'b0;
      eoc_o    <= 1'b0;
    end else begin
      state_q  <= state_d;
      if (load_o)
        idx_q <= TOP_IDX;
      else if (step_o && !last_o)
        idx_q <= idx_q - 1'b1;
      busy_o   <= (state_d != ST_IDLE);
      clk_en_o <= (state_d == ST_CONV);
      eoc_o    <= (state_q == ST_END);
    end
  end

  // R2
  conv_holds_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV) |=> busy_o);

  // R4
  idx_walks_down_chk: assert property (@(posedge clk) disable iff (rst)
    (step_o && !last_o) |=> (step_o && idx_q == $past(idx_q) - 1'b1));
endmodule

// File: rtl/sar_register.sv
module sar_register #(
  parameter int W  = 12,
  parameter int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          last_i,
  input  logic [IW-1:0] idx_i,
  input  logic          keep_i,
  output logic [W-1:0]  trial_o,
  output logic [W-1:0]  result_o
);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] sel;
  logic [W-1:0] decided;
  logic [W-1:0] next_bit;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign sel[i]     = (idx_i == IW'(i));
      assign decided[i] = sel[i] ? (trial_o[i] & keep_i) : trial_o[i];
      if (i < W - 1) begin : g_lower
        assign next_bit[i] = (idx_i == IW'(i + 1));
      end else begin : g_top
        assign next_bit[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_o  <= '0;
      result_o <= '0;
    end else if (load_i) begin
      trial_o  <= MSB_ONLY;
      result_o <= '0;
    end else if (step_i) begin
      if (last_i) begin
        trial_o  <= decided;
        result_o <= decided;
      end else begin
        trial_o  <= decided | next_bit;
      end
    end
  end

  // R1
  load_msb_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (trial_o == MSB_ONLY));

  // R4
  low_bits_clear_chk: assert property (@(posedge clk) disable iff (rst)
    step_i |-> (trial_o[idx_i] && ((trial_o & ((W'(1) << idx_i) - 1'b1)) == '0)));

  // R5
  drop_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !keep_i) |=> !trial_o[$past(idx_i)]);
endmodule

// File: rtl/sar_outbuf.sv
module sar_outbuf #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_i,
  input  logic         idle_next_i,
  input  logic [W-1:0] result_i,
  output logic         oe_o,
  output logic [W-1:0] data_o
);
  logic grant;
  assign grant = rd_i && idle_next_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_o   <= 1'b0;
      data_o <= '0;
    end else begin
      oe_o   <= grant;
      data_o <= grant ? result_i : '0;
    end
  end

  // R8
  gated_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_o |-> (data_o == '0));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         cmp_keep_i,
  input  logic         read_i,
  output logic         conv_clk_en_o,
  output logic         busy_o,
  output logic         eoc_o,
  output logic [W-1:0] trial_o,
  output logic         data_oe_o,
  output logic [W-1:0] data_o
);
  localparam int IW = $clog2(W);

  logic          load, step, last, idle_next;
  logic [IW-1:0] idx;
  logic [W-1:0]  result;

  sar_sequencer #(.W(W), .IW(IW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .load_o     (load),
    .step_o     (step),
    .last_o     (last),
    .idx_o      (idx),
    .idle_next_o(idle_next),
    .busy_o     (busy_o),
    .clk_en_o   (conv_clk_en_o),
    .eoc_o      (eoc_o)
  );

  sar_register #(.W(W), .IW(IW)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .step_i  (step),
    .last_i  (last),
    .idx_i   (idx),
    .keep_i  (cmp_keep_i),
    .trial_o (trial_o),
    .result_o(result)
  );

  sar_outbuf #(.W(W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .rd_i       (read_i),
    .idle_next_i(idle_next),
    .result_i   (result),
    .oe_o       (data_oe_o),
    .data_o     (data_o)
  );

  // R3
  busy_blocks_read_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !data_oe_o);

  // R7
  eoc_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    eoc_o |-> (!busy_o && !conv_clk_en_o && $fell(busy_o)));

  // R7
  gate_within_busy_chk: assert property (@(posedge clk) disable iff (rst)
    conv_clk_en_o |-> busy_o);

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!busy_o && !conv_clk_en_o && !data_oe_o));
endmodule

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        read = 1'b0;
  logic [11:0] vin = '0;
  logic        cmp;
  logic        clk_en, busy, eoc, oe;
  logic [11:0] trial, data;

  int vectors = 0;
  int fails = 0;
  bit seen_edge = 0;

  always #10 clk = ~clk;

  assign cmp = (trial <= vin);

  sar_adc_ctrl dut (
    .clk(clk), .rst(rst), .start_i(start), .cmp_keep_i(cmp), .read_i(read),
    .conv_clk_en_o(clk_en), .busy_o(busy), .eoc_o(eoc), .trial_o(trial),
    .data_oe_o(oe), .data_o(data)
  );

  // behavioural reference: cycles since accepted start
  int          m_cnt = 0;
  int          nc;
  logic        acc;
  logic        m_busy = 0, m_clken = 0, m_eoc = 0, m_oe = 0;
  logic [11:0] m_res = '0, m_data = '0, m_trial = '0;

  function automatic logic [11:0] exp_trial(input logic [11:0] v, input int b);
    int keep_mask = ~((1 << (b + 1)) - 1);
    return 12'((int'(v) & keep_mask) | (1 << b));
  endfunction

  always @(posedge clk) begin
    seen_edge <= 1;
    if (rst) begin
      m_cnt <= 0; m_busy <= 0; m_clken <= 0; m_eoc <= 0;
      m_oe <= 0; m_data <= '0; m_res <= '0; m_trial <= '0;
    end else begin
      acc = (m_cnt == 0) && start;
      nc = acc ? 1 : (m_cnt == 13) ? 0 : (m_cnt != 0) ? m_cnt + 1 : 0;
      m_cnt   <= nc;
      m_busy  <= (nc != 0);
      m_clken <= (nc >= 1 && nc <= 12);
      m_eoc   <= (m_cnt == 13);
      if (acc) m_res <= '0;
      else if (m_cnt == 12) m_res <= vin;
      m_oe   <= read && (nc == 0);
      m_data <= (read && nc == 0) ? m_res : '0;
      if (nc >= 1 && nc <= 12) m_trial <= exp_trial(vin, 12 - nc);
      else if (m_cnt == 12) m_trial <= vin;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (seen_edge) begin
      chk("R6", "busy", busy, m_busy);
      chk("R7", "clk_en", clk_en, m_clken);
      chk("R7", "eoc", eoc, m_eoc);
      chk(m_cnt == 1 ? "R1" : "R4", "trial", trial, m_trial);
      chk(m_busy ? "R3" : "R8", "oe", oe, m_oe);
      chk(m_busy ? "R3" : "R8", "data", data, m_data);
    end
  end

  task automatic run_conv(input logic [11:0] v, input bit hold_start, input bit rd_during);
    @(negedge clk);
    vin = v; start = 1; read = rd_during;
    @(negedge clk);
    if (!hold_start) start = 0;
    chk("R1", "first trial", trial, 12'h800);
    @(negedge clk);
    chk("R5", "msb decision", trial[11], v[11]);
    if (hold_start) start = 1;
    repeat (11) @(negedge clk);
    chk("R2", "busy in control cycle", busy, 1);
    start = 0;
    @(negedge clk);
    chk("R6", "busy dropped", busy, 0);
    read = 0;
  endtask

  task automatic read_twice(input logic [11:0] v);
    @(negedge clk); read = 1;
    @(negedge clk);
    chk("R9", "first read", data, v);
    @(negedge clk);
    chk("R9", "repeat read", data, v);
    read = 0;
    @(negedge clk);
    chk("R8", "read released", data, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset busy", busy, 0);
    chk("R10", "reset data", data, 0);
    rst = 0;
    @(negedge clk);
    run_conv(12'h000, 0, 0); read_twice(12'h000);
    run_conv(12'hFFF, 1, 1); read_twice(12'hFFF);
    run_conv(12'h800, 0, 1); read_twice(12'h800);
    run_conv(12'h7FF, 1, 0); read_twice(12'h7FF);
    run_conv(12'hA5A, 0, 0); read_twice(12'hA5A);
    run_conv(12'h5A5, 0, 1);
    // start on the end pulse cycle: back-to-back conversion
    start = 1; vin = 12'h001;
    @(negedge clk); start = 0;
    chk("R1", "chained start", busy, 1);
    repeat (13) @(negedge clk);
    read_twice(12'h001);
    // start and read on the same edge: start wins
    @(negedge clk); start = 1; read = 1; vin = 12'h3C3;
    @(negedge clk); start = 0;
    chk("R8", "read lost to start", oe, 0);
    repeat (14) @(negedge clk);
    read = 0;
    read_twice(12'h3C3);
    // reset in the middle of a conversion
    @(negedge clk); start = 1; vin = 12'hBEE;
    @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    rst = 1;
    @(negedge clk); rst = 0;
    chk("R10", "reset mid busy", busy, 0);
    chk("R10", "reset mid gate", clk_en, 0);
    read_twice(12'h000);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule